// File: doc/BRIEF.md
# DRAM Channel Bring-Up Sequencer

This block is the control state machine that takes two DRAM controller channels from power-on to normal operation. It drives a simple strobe-style command port that feeds both channels at once. Each command carries an opcode and a chip-select. The sequencer runs handshakes with the PHY for impedance calibration, interface init, gate leveling and read-offset calibration. It polls completion inputs and finishes with a `done` level and a 2-bit error code. Timing values, calibration results and register contents are not interpreted here. They appear only as opaque data paths and strobes.

A run starts with a `start` pulse while the block is idle. `resume` and `two_chips` are sampled at that moment. On a cold boot the sequencer sends the device initialisation command group and calibrates the read offsets. It then hands the result to an external retained store. On a resume the mode-register group is never sent, because that group would wipe memory contents. Instead the sequencer releases pad retention and waits for the retention status. It then keeps the devices alive with a refresh burst before any leveling, and loads the saved read offsets back rather than recalibrating. Both paths end with precharge-all, a memory-control write, and the auto-refresh and I/O power-down enables.

States: `S_IDLE`, `S_ZQ`, `S_DFI_SET`, `S_DFI_CLR`, `S_MRS`, `S_RET_REL`, `S_RET_WAIT`, `S_REFRESH`, `S_LVL0`, `S_LVL1`, `S_RD_CAL`, `S_OFF_SAVE`, `S_OFF_LOAD`, `S_PALL`, `S_MEMCTL`, `S_AREF`.

Transitions:
- `S_IDLE`→`S_ZQ` on `start`.
- `S_ZQ`→`S_DFI_SET` on `zq_done` without `zq_fail`.
- `S_ZQ`→`S_IDLE` on `zq_done` with `zq_fail`.
- `S_DFI_SET`→`S_DFI_CLR` when both init-done bits are high.
- `S_DFI_CLR`→`S_MRS` (cold) or →`S_RET_REL` (resume).
- `S_MRS`→`S_LVL0` after the last group command.
- `S_RET_REL`→`S_RET_WAIT`.
- `S_RET_WAIT`→`S_REFRESH` when status equals 2'b01.
- `S_REFRESH`→`S_LVL0` after the last refresh.
- `S_LVL0`→`S_LVL1` on `lvl_done[0]`.
- `S_LVL1`→`S_RD_CAL` (cold) or →`S_OFF_LOAD` (resume) on `lvl_done[1]`.
- `S_LVL0` or `S_LVL1`→`S_IDLE` on poll timeout.
- `S_RD_CAL`→`S_OFF_SAVE` on `cal_done`.
- `S_OFF_SAVE` and `S_OFF_LOAD`→`S_PALL`.
- `S_PALL`→`S_MEMCTL` after the last precharge.
- `S_MEMCTL`→`S_AREF`.
- `S_AREF`→`S_IDLE`.

Top module: `dram_bringup_seq`

## Requirements
- R1: Out of reset every output is low, `err` is 0 and `done` is 0.
- R2: After `start`, `zq_req` is high until `zq_done`. If `zq_fail` is high with it, `err` becomes 2, `done` rises, and no command or init request is issued.
- R3: `dfi_init_start` is 2'b11 until both bits of `dfi_init_done` are high in the same cycle. It then drops, and no command is issued while it is high.
- R4: On a cold boot, each chip select in turn receives NOP (op 0), MRS (op 2) and ZQINIT (op 3). Every command strobes both channels (`cmd_en` = 2'b11), and `cmd_cs` carries the chip index.
- R5: On a resume, no MRS is ever sent. `ret_release` pulses for one cycle, and no command follows until `ret_status` reads exactly 2'b01. The first refresh appears the cycle after that value is seen.
- R6: On a resume, REF_ROUNDS (128) rounds of all-bank refresh (op 4) are issued. Each round visits chip 0 and then chip 1 when two chips are configured.
- R7: Gate leveling runs on channel 0 (`lvl_en` = 2'b01) until `lvl_done[0]`, and then on channel 1 (2'b10) until `lvl_done[1]`. Both bits are never high together.
- R8: Each leveling wait polls at most POLL_MAX (10000) times, and completion seen on the last poll is accepted. If there is no completion within that limit, `err` becomes 1, `done` rises, and the sequence stops.
- R9: On a cold boot, `cal_req` is held until `cal_done`. Then `save_we` pulses once with `off_wdata` equal to `phy_off`. On a resume, `restore_we` pulses once with `off_wdata` equal to `kept_off`, and `cal_req` never rises.
- R10: After the offsets, precharge-all (op 1) goes to each chip select. `memctl_we` pulses the next cycle. `aref_en` and `iopd_en` rise together one cycle later, and `done` rises one cycle after that with `err` 0.
- R11: `done`, `err`, `aref_en` and `iopd_en` hold their values until the next `start`, which clears them. A `start` pulse clears `done` within one cycle.
- R12: `two_chips` sampled at `start` selects one chip select (0) or two (0 and 1) for every command loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a bring-up run (accepted when idle) |
| resume | input | 1 | 1 = resume with retained memory, 0 = cold boot; sampled at start |
| two_chips | input | 1 | 1 = two chip selects, 0 = one; sampled at start |
| zq_req | output | 1 | Impedance calibration request |
| zq_done | input | 1 | Calibration finished |
| zq_fail | input | 1 | Calibration failed, valid with zq_done |
| dfi_init_start | output | 2 | Interface init request per channel |
| dfi_init_done | input | 2 | Interface init complete per channel |
| ret_release | output | 1 | One-cycle pad retention release |
| ret_status | input | 2 | Retention status, 2'b01 = released |
| cmd_en | output | 2 | Command strobe per channel |
| cmd_op | output | 3 | Opcode: 0 NOP, 1 PALL, 2 MRS, 3 ZQINIT, 4 REFA |
| cmd_cs | output | 1 | Chip select of the command |
| lvl_en | output | 2 | Gate leveling enable per channel |
| lvl_done | input | 2 | Gate leveling complete per channel |
| cal_req | output | 1 | Read-offset calibration request |
| cal_done | input | 1 | Read-offset calibration finished |
| phy_off | input | 2*OFF_W | Calibrated read offsets of both channels |
| kept_off | input | 2*OFF_W | Read offsets held by the retained store |
| save_we | output | 1 | Write strobe to the retained store |
| restore_we | output | 1 | Write strobe to the PHY offset registers |
| off_wdata | output | 2*OFF_W | Offset data for save_we or restore_we |
| memctl_we | output | 1 | Memory-control setting write strobe |
| aref_en | output | 1 | Auto-refresh enable (held) |
| iopd_en | output | 1 | I/O power-down mode enable (held) |
| done | output | 1 | Run finished (held until next start) |
| err | output | 2 | 0 ok, 1 leveling timeout, 2 calibration failure |

## Verification
The sharpest collision in this block is a leveling completion arriving in the same cycle as the poll timer's final count. Completion and timeout are then both asserted at one clock edge. The bench provokes this by raising `lvl_done[0]` on exactly the POLL_MAX-th poll, and judges it by requiring a clean finish with `err` 0 and a channel-0 window of exactly POLL_MAX cycles. It then raises the same signal one poll later and requires `err` 1, no channel-1 leveling and no precharge. The second overlap is the resume path's status wait against the first refresh. A non-exact status value (2'b11) is held before 2'b01 appears, and the first refresh must land exactly one cycle after the valid value.

// File: rtl/bringup_pkg.sv
package bringup_pkg;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_PALL   = 3'd1,
        OP_MRS    = 3'd2,
        OP_ZQINIT = 3'd3,
        OP_REFA   = 3'd4
    } cmd_op_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_LVL_TMO = 2'd1,
        ERR_ZQ      = 2'd2
    } err_code_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ZQ,
        S_DFI_SET,
        S_DFI_CLR,
        S_MRS,
        S_RET_REL,
        S_RET_WAIT,
        S_REFRESH,
        S_LVL0,
        S_LVL1,
        S_RD_CAL,
        S_OFF_SAVE,
        S_OFF_LOAD,
        S_PALL,
        S_MEMCTL,
        S_AREF
    } seq_state_e;

    localparam logic [1:0] RET_RELEASED = 2'b01;
    localparam logic [1:0] MRS_GROUP_LAST = 2'd2;

endpackage

// File: rtl/bup_poll_timer.sv
module bup_poll_timer #(
    parameter int unsigned POLL_MAX = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic expired
);
    localparam int unsigned CNT_W = $clog2(POLL_MAX + 1);
    localparam logic [CNT_W-1:0] LAST_POLL = CNT_W'(POLL_MAX - 1);

    logic [CNT_W-1:0] cnt_q;

    assign expired = (cnt_q == LAST_POLL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (tick && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_POLL) else $error("poll counter beyond limit"); // R8

endmodule

// File: rtl/bup_cmd_walker.sv
module bup_cmd_walker #(
    parameter int unsigned ROUND_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               step,
    input  logic               multi_chip,
    input  logic [1:0]         phase_last,
    input  logic [ROUND_W-1:0] round_last,
    output logic [1:0]         phase,
    output logic               chip,
    output logic               last
);
    logic [ROUND_W-1:0] round_q;
    logic               phase_end;
    logic               chip_end;
    logic               round_end;

    assign phase_end = (phase == phase_last);
    assign chip_end  = (chip == multi_chip);
    assign round_end = (round_q == round_last);
    assign last      = phase_end && chip_end && round_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase   <= '0;
            chip    <= 1'b0;
            round_q <= '0;
        end else if (clear) begin
            phase   <= '0;
            chip    <= 1'b0;
            round_q <= '0;
        end else if (step) begin
            if (phase_end) begin
                phase <= '0;
                if (chip_end) begin
                    chip    <= 1'b0;
                    round_q <= round_q + 1'b1;
                end else begin
                    chip <= 1'b1;
                end
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

    AST_SINGLE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!multi_chip && step) |-> (chip == 1'b0)) else $error("chip 1 used with one chip"); // R12

endmodule

// File: rtl/dram_bringup_seq.sv
module dram_bringup_seq
    import bringup_pkg::*;
#(
    parameter int unsigned OFF_W      = 32,
    parameter int unsigned POLL_MAX   = 10000,
    parameter int unsigned REF_ROUNDS = 128
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 resume,
    input  logic                 two_chips,
    output logic                 zq_req,
    input  logic                 zq_done,
    input  logic                 zq_fail,
    output logic [1:0]           dfi_init_start,
    input  logic [1:0]           dfi_init_done,
    output logic                 ret_release,
    input  logic [1:0]           ret_status,
    output logic [1:0]           cmd_en,
    output logic [2:0]           cmd_op,
    output logic                 cmd_cs,
    output logic [1:0]           lvl_en,
    input  logic [1:0]           lvl_done,
    output logic                 cal_req,
    input  logic                 cal_done,
    input  logic [2*OFF_W-1:0]   phy_off,
    input  logic [2*OFF_W-1:0]   kept_off,
    output logic                 save_we,
    output logic                 restore_we,
    output logic [2*OFF_W-1:0]   off_wdata,
    output logic                 memctl_we,
    output logic                 aref_en,
    output logic                 iopd_en,
    output logic                 done,
    output logic [1:0]           err
);
    localparam int unsigned ROUND_W = (REF_ROUNDS > 1) ? $clog2(REF_ROUNDS) : 1;
    localparam logic [ROUND_W-1:0] REF_LAST = ROUND_W'(REF_ROUNDS - 1);

    seq_state_e state_q, state_d;

    logic       resume_q;
    logic       two_chips_q;
    logic       done_q;
    err_code_e  err_q;
    logic       aref_q;
    logic       iopd_q;

    logic       in_lvl;
    logic       lvl_hit;
    logic       tmr_clear;
    logic       tmr_expired;
    logic       lvl_timeout;

    logic             walk_clear;
    logic             walk_step;
    logic [1:0]       walk_phase;
    logic             walk_chip;
    logic             walk_last;
    logic [1:0]       walk_phase_last;
    logic [ROUND_W-1:0] walk_round_last;

    // leveling poll window
    assign in_lvl      = (state_q == S_LVL0) || (state_q == S_LVL1);
    assign lvl_hit     = ((state_q == S_LVL0) && lvl_done[0]) ||
                         ((state_q == S_LVL1) && lvl_done[1]);
    assign tmr_clear   = !in_lvl || lvl_hit;
    assign lvl_timeout = in_lvl && !lvl_hit && tmr_expired;

    bup_poll_timer #(
        .POLL_MAX (POLL_MAX)
    ) u_poll_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clear),
        .tick    (in_lvl),
        .expired (tmr_expired)
    );

    // command loop walker: rounds x chips x phases
    assign walk_clear      = (state_d != state_q);
    assign walk_step       = (state_q == S_MRS) || (state_q == S_REFRESH) ||
                             (state_q == S_PALL);
    assign walk_phase_last = (state_q == S_MRS) ? MRS_GROUP_LAST : 2'd0;
    assign walk_round_last = (state_q == S_REFRESH) ? REF_LAST : '0;

    bup_cmd_walker #(
        .ROUND_W (ROUND_W)
    ) u_cmd_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (walk_clear),
        .step       (walk_step),
        .multi_chip (two_chips_q),
        .phase_last (walk_phase_last),
        .round_last (walk_round_last),
        .phase      (walk_phase),
        .chip       (walk_chip),
        .last       (walk_last)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (start) state_d = S_ZQ;
            S_ZQ:       if (zq_done) state_d = zq_fail ? S_IDLE : S_DFI_SET;
            S_DFI_SET:  if (&dfi_init_done) state_d = S_DFI_CLR;
            S_DFI_CLR:  state_d = resume_q ? S_RET_REL : S_MRS;
            S_MRS:      if (walk_last) state_d = S_LVL0;
            S_RET_REL:  state_d = S_RET_WAIT;
            S_RET_WAIT: if (ret_status == RET_RELEASED) state_d = S_REFRESH;
            S_REFRESH:  if (walk_last) state_d = S_LVL0;
            S_LVL0: begin
                if (lvl_done[0])      state_d = S_LVL1;
                else if (tmr_expired) state_d = S_IDLE;
            end
            S_LVL1: begin
                if (lvl_done[1])      state_d = resume_q ? S_OFF_LOAD : S_RD_CAL;
                else if (tmr_expired) state_d = S_IDLE;
            end
            S_RD_CAL:   if (cal_done) state_d = S_OFF_SAVE;
            S_OFF_SAVE: state_d = S_PALL;
            S_OFF_LOAD: state_d = S_PALL;
            S_PALL:     if (walk_last) state_d = S_MEMCTL;
            S_MEMCTL:   state_d = S_AREF;
            S_AREF:     state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // state register and held run results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            resume_q    <= 1'b0;
            two_chips_q <= 1'b0;
            done_q      <= 1'b0;
            err_q       <= ERR_NONE;
            aref_q      <= 1'b0;
            iopd_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            if ((state_q == S_IDLE) && start) begin
                resume_q    <= resume;
                two_chips_q <= two_chips;
                done_q      <= 1'b0;
                err_q       <= ERR_NONE;
                aref_q      <= 1'b0;
                iopd_q      <= 1'b0;
            end
            if ((state_q == S_ZQ) && zq_done && zq_fail) begin
                err_q  <= ERR_ZQ;
                done_q <= 1'b1;
            end
            if (lvl_timeout) begin
                err_q  <= ERR_LVL_TMO;
                done_q <= 1'b1;
            end
            if (state_q == S_MEMCTL) begin
                aref_q <= 1'b1;
                iopd_q <= 1'b1;
            end
            if (state_q == S_AREF) begin
                done_q <= 1'b1;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        zq_req         = 1'b0;
        dfi_init_start = 2'b00;
        ret_release    = 1'b0;
        cmd_en         = 2'b00;
        cmd_op         = OP_NOP;
        cmd_cs         = walk_chip;
        lvl_en         = 2'b00;
        cal_req        = 1'b0;
        save_we        = 1'b0;
        restore_we     = 1'b0;
        off_wdata      = '0;
        memctl_we      = 1'b0;
        unique case (state_q)
            S_ZQ:       zq_req = 1'b1;
            S_DFI_SET:  dfi_init_start = 2'b11;
            S_MRS: begin
                cmd_en = 2'b11;
                unique case (walk_phase)
                    2'd0:    cmd_op = OP_NOP;
                    2'd1:    cmd_op = OP_MRS;
                    default: cmd_op = OP_ZQINIT;
                endcase
            end
            S_RET_REL:  ret_release = 1'b1;
            S_REFRESH: begin
                cmd_en = 2'b11;
                cmd_op = OP_REFA;
            end
            S_LVL0:     lvl_en = 2'b01;
            S_LVL1:     lvl_en = 2'b10;
            S_RD_CAL:   cal_req = 1'b1;
            S_OFF_SAVE: begin
                save_we   = 1'b1;
                off_wdata = phy_off;
            end
            S_OFF_LOAD: begin
                restore_we = 1'b1;
                off_wdata  = kept_off;
            end
            S_PALL: begin
                cmd_en = 2'b11;
                cmd_op = OP_PALL;
            end
            S_MEMCTL:   memctl_we = 1'b1;
            default: ;
        endcase
    end

    assign aref_en = aref_q;
    assign iopd_en = iopd_q;
    assign done    = done_q;
    assign err     = err_q;

    AST_DFI_DROP_ON_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dfi_init_start[0]) |-> $past(&dfi_init_done)) else $error("init start dropped early"); // R3
    AST_NO_CMD_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        (dfi_init_start != 2'b00) |-> (cmd_en == 2'b00)) else $error("command during init"); // R3
    AST_ZQ_FAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done_q) && (err_q == ERR_ZQ)) |-> $past(zq_done && zq_fail)) else $error("bad zq error"); // R2
    AST_RET_STATUS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_REFRESH) && ($past(state_q) == S_RET_WAIT)) |-> ($past(ret_status) == RET_RELEASED))
        else $error("refresh before retention release"); // R5
    AST_NO_MRS_ON_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_q && (cmd_en != 2'b00)) |-> (cmd_op != OP_MRS)) else $error("MRS on resume"); // R5
    AST_LVL1_AFTER_LVL0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lvl_en[1]) |-> $past(lvl_done[0])) else $error("channel 1 leveled first"); // R7
    AST_TMO_FROM_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done_q) && (err_q == ERR_LVL_TMO)) |-> $past(tmr_expired)) else $error("timeout without expiry"); // R8
    AST_SAVE_AFTER_CAL: assert property (@(posedge clk) disable iff (!rst_n)
        save_we |-> $past(cal_done)) else $error("save before calibration"); // R9
    AST_AREF_AFTER_MEMCTL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aref_en) |-> $past(memctl_we)) else $error("auto-refresh too early"); // R10

endmodule

// File: tb/dram_bringup_seq_tb.sv
module dram_bringup_seq_tb;
    localparam int OFF_W    = 32;
    localparam int POLL_MAX = 10000;
    localparam int LOG_N    = 300;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0;
    logic start = 1'b0, resume = 1'b0, two_chips = 1'b0;
    logic zq_req, zq_done = 1'b0, zq_fail = 1'b0;
    logic [1:0] dfi_init_start, dfi_init_done = 2'b00;
    logic ret_release;
    logic [1:0] ret_status = 2'b00;
    logic [1:0] cmd_en;
    logic [2:0] cmd_op;
    logic cmd_cs;
    logic [1:0] lvl_en, lvl_done = 2'b00;
    logic cal_req, cal_done = 1'b0;
    logic [2*OFF_W-1:0] phy_off  = 64'h1357_9bdf_2468_ace0;
    logic [2*OFF_W-1:0] kept_off = 64'h0f1e_2d3c_4b5a_6978;
    logic save_we, restore_we;
    logic [2*OFF_W-1:0] off_wdata;
    logic memctl_we, aref_en, iopd_en, done;
    logic [1:0] err;

    dram_bringup_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .resume(resume), .two_chips(two_chips),
        .zq_req(zq_req), .zq_done(zq_done), .zq_fail(zq_fail),
        .dfi_init_start(dfi_init_start), .dfi_init_done(dfi_init_done),
        .ret_release(ret_release), .ret_status(ret_status),
        .cmd_en(cmd_en), .cmd_op(cmd_op), .cmd_cs(cmd_cs),
        .lvl_en(lvl_en), .lvl_done(lvl_done), .cal_req(cal_req), .cal_done(cal_done),
        .phy_off(phy_off), .kept_off(kept_off), .save_we(save_we), .restore_we(restore_we),
        .off_wdata(off_wdata), .memctl_we(memctl_we), .aref_en(aref_en), .iopd_en(iopd_en),
        .done(done), .err(err)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // observation record of one run
    int op_log [LOG_N];
    int cs_log [LOG_N];
    int n_cmd, bad_both, cmd_in_init, overlap;
    int dfi_cyc, lvl0_cyc, lvl1_cyc, lvl0_last, lvl1_first, last_cmd_cyc;
    int rel_cyc, stat01_cyc, first_ref_cyc, n_rel, cal_cyc;
    int memctl_cyc, aref_cyc, iopd_cyc, done_cyc, n_save, n_restore;
    logic [2*OFF_W-1:0] save_data, restore_data;
    bit done_at_first;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_seq(input bit rs, input bit two, input int lat0, input int lat1, input bit zqbad);
        int cyc, zq_n, d0, d1, k0, k1, cal_n;
        cyc = 0; zq_n = 0; d0 = 0; d1 = 0; k0 = 0; k1 = 0; cal_n = 0;
        n_cmd = 0; bad_both = 0; cmd_in_init = 0; overlap = 0;
        dfi_cyc = 0; lvl0_cyc = 0; lvl1_cyc = 0; lvl0_last = -1; lvl1_first = -1; last_cmd_cyc = -1;
        rel_cyc = -1; stat01_cyc = -1; first_ref_cyc = -1; n_rel = 0; cal_cyc = 0;
        memctl_cyc = -1; aref_cyc = -1; iopd_cyc = -1; done_cyc = -1; n_save = 0; n_restore = 0;
        save_data = '0; restore_data = '0; done_at_first = 1'b0;
        dfi_init_done = 2'b00; ret_status = 2'b00; lvl_done = 2'b00; cal_done = 1'b0;
        zq_done = 1'b0; zq_fail = 1'b0;
        @(negedge clk);
        resume = rs; two_chips = two; start = 1'b1;
        while (done_cyc < 0 && cyc < 30000) begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
            if (cyc == 1) done_at_first = done;
            // observe
            if (cmd_en != 2'b00) begin
                if (cmd_en != 2'b11) bad_both++;
                if (dfi_init_start != 2'b00) cmd_in_init++;
                if (n_cmd < LOG_N) begin
                    op_log[n_cmd] = int'(cmd_op);
                    cs_log[n_cmd] = int'(cmd_cs);
                end
                if (cmd_op == 3'd4 && first_ref_cyc < 0) first_ref_cyc = cyc;
                n_cmd++;
                last_cmd_cyc = cyc;
            end
            if (dfi_init_start != 2'b00) dfi_cyc++;
            if (lvl_en == 2'b11) overlap++;
            if (lvl_en[0]) begin lvl0_cyc++; lvl0_last = cyc; end
            if (lvl_en[1]) begin lvl1_cyc++; if (lvl1_first < 0) lvl1_first = cyc; end
            if (ret_release) begin n_rel++; if (rel_cyc < 0) rel_cyc = cyc; end
            if (cal_req) cal_cyc++;
            if (save_we) begin n_save++; save_data = off_wdata; end
            if (restore_we) begin n_restore++; restore_data = off_wdata; end
            if (memctl_we) memctl_cyc = cyc;
            if (aref_en && aref_cyc < 0) aref_cyc = cyc;
            if (iopd_en && iopd_cyc < 0) iopd_cyc = cyc;
            if (done && cyc > 1) done_cyc = cyc;
            // respond
            if (zq_req) begin zq_n++; zq_done = (zq_n >= 2); zq_fail = zqbad; end
            else begin zq_done = 1'b0; zq_fail = 1'b0; end
            if (dfi_init_start[0]) d0++;
            if (dfi_init_start[1]) d1++;
            if (d0 >= 3) dfi_init_done[0] = 1'b1;
            if (d1 >= 7) dfi_init_done[1] = 1'b1;
            if (rel_cyc >= 0) begin
                if (cyc - rel_cyc < 4) ret_status = 2'b11;
                else begin
                    ret_status = 2'b01;
                    if (stat01_cyc < 0) stat01_cyc = cyc;
                end
            end
            if (lvl_en[0]) k0++;
            if (lvl_en[1]) k1++;
            lvl_done[0] = lvl_en[0] && (k0 >= lat0);
            lvl_done[1] = lvl_en[1] && (k1 >= lat1);
            if (cal_req) begin cal_n++; cal_done = (cal_n >= 4); end
            else cal_done = 1'b0;
        end
        if (done_cyc < 0) check(1'b0, "R11", "watchdog: run never finished", cyc, 0);
        check(done_at_first == 1'b0, "R11", "done cleared by start", int'(done_at_first), 0);
    endtask

    task automatic check_hold(input int exp_err, input bit exp_aref);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(done == 1'b1 && int'(err) == exp_err && aref_en == exp_aref, "R11",
                  "result held after run", int'(err), exp_err);
        end
    endtask

    task automatic test_reset();
        check({zq_req, dfi_init_start, ret_release, cmd_en, lvl_en, cal_req} == '0, "R1",
              "request outputs after reset", int'(cmd_en), 0);
        check({save_we, restore_we, memctl_we, aref_en, iopd_en} == '0, "R1",
              "strobes after reset", int'(aref_en), 0);
        check(done == 1'b0 && err == 2'd0, "R1", "done/err after reset", int'(err), 0);
    endtask

    task automatic test_cold_two();
        int exp_op [8] = '{0, 2, 3, 0, 2, 3, 1, 1};
        int exp_cs [8] = '{0, 0, 0, 1, 1, 1, 0, 1};
        run_seq(1'b0, 1'b1, 5, 9, 1'b0);
        check(n_cmd == 8, "R4", "cold two-chip command count", n_cmd, 8);
        for (int i = 0; i < 8; i++) begin
            check(op_log[i] == exp_op[i], "R4", $sformatf("cold op #%0d", i), op_log[i], exp_op[i]);
            check(cs_log[i] == exp_cs[i], "R12", $sformatf("cold cs #%0d", i), cs_log[i], exp_cs[i]);
        end
        check(bad_both == 0, "R4", "commands strobe both channels", bad_both, 0);
        check(dfi_cyc == 7, "R3", "init start held until both done", dfi_cyc, 7);
        check(cmd_in_init == 0, "R3", "no command during init", cmd_in_init, 0);
        check(n_rel == 0, "R5", "no retention release on cold boot", n_rel, 0);
        check(lvl0_cyc == 5 && lvl1_cyc == 9, "R7", "leveling windows ch0", lvl0_cyc, 5);
        check(lvl1_first == lvl0_last + 1, "R7", "ch1 follows ch0", lvl1_first, lvl0_last + 1);
        check(overlap == 0, "R7", "leveling never on both", overlap, 0);
        check(cal_cyc == 4, "R9", "calibration request held until done", cal_cyc, 4);
        check(n_save == 1 && save_data == phy_off, "R9", "saved offsets", int'(save_data[31:0]), int'(phy_off[31:0]));
        check(n_restore == 0, "R9", "no restore on cold boot", n_restore, 0);
        check(memctl_cyc == last_cmd_cyc + 1, "R10", "memctl after last precharge", memctl_cyc, last_cmd_cyc + 1);
        check(aref_cyc == memctl_cyc + 1, "R10", "auto-refresh after memctl", aref_cyc, memctl_cyc + 1);
        check(iopd_cyc == aref_cyc, "R10", "io power-down with auto-refresh", iopd_cyc, aref_cyc);
        check(done_cyc == memctl_cyc + 2 && err == 2'd0, "R10", "done after enables", done_cyc, memctl_cyc + 2);
        check_hold(0, 1'b1);
    endtask

    task automatic test_cold_one();
        int exp_op [4] = '{0, 2, 3, 1};
        run_seq(1'b0, 1'b0, 1, 1, 1'b0);
        check(n_cmd == 4, "R12", "one-chip cold command count", n_cmd, 4);
        for (int i = 0; i < 4; i++) begin
            check(op_log[i] == exp_op[i] && cs_log[i] == 0, "R12", $sformatf("one-chip op #%0d", i),
                  op_log[i], exp_op[i]);
        end
        check(done_cyc > 0 && err == 2'd0, "R10", "one-chip cold finish", int'(err), 0);
    endtask

    task automatic test_resume(input bit two);
        int chips, nref, bad_ref, n_mrs;
        chips = two ? 2 : 1;
        nref = 128 * chips;
        bad_ref = 0; n_mrs = 0;
        run_seq(1'b1, two, 3, 3, 1'b0);
        check(n_cmd == nref + chips, "R6", "resume command count", n_cmd, nref + chips);
        for (int i = 0; i < nref && i < LOG_N; i++) begin
            if (op_log[i] != 4 || cs_log[i] != (i % chips)) bad_ref++;
        end
        for (int i = 0; i < n_cmd && i < LOG_N; i++) if (op_log[i] == 2) n_mrs++;
        check(bad_ref == 0, "R6", "refresh burst op/cs order", bad_ref, 0);
        check(n_mrs == 0, "R5", "no MRS on resume", n_mrs, 0);
        check(n_rel == 1, "R5", "single retention release pulse", n_rel, 1);
        check(first_ref_cyc == stat01_cyc + 1, "R5", "first refresh after status 01", first_ref_cyc, stat01_cyc + 1);
        check(lvl0_last > 0 && lvl0_last - lvl0_cyc + 1 > first_ref_cyc + nref - 1, "R6",
              "refresh burst before leveling", lvl0_last - lvl0_cyc + 1, first_ref_cyc + nref);
        check(cal_cyc == 0 && n_save == 0, "R9", "no calibration on resume", cal_cyc, 0);
        check(n_restore == 1 && restore_data == kept_off, "R9", "restored offsets",
              int'(restore_data[31:0]), int'(kept_off[31:0]));
        check(op_log[nref] == 1 && aref_cyc == memctl_cyc + 1, "R10", "resume tail", op_log[nref], 1);
        check_hold(0, 1'b1);
    endtask

    task automatic test_zq_fail();
        run_seq(1'b0, 1'b1, 1, 1, 1'b1);
        check(int'(err) == 2, "R2", "calibration failure code", int'(err), 2);
        check(n_cmd == 0 && dfi_cyc == 0, "R2", "nothing issued after failure", n_cmd, 0);
        check(aref_cyc < 0, "R2", "no auto-refresh after failure", aref_cyc, -1);
        check_hold(2, 1'b0);
    endtask

    task automatic test_timeout();
        run_seq(1'b0, 1'b1, POLL_MAX + 1, 1, 1'b0);
        check(int'(err) == 1, "R8", "leveling timeout code", int'(err), 1);
        check(lvl0_cyc == POLL_MAX, "R8", "polls before timeout", lvl0_cyc, POLL_MAX);
        check(lvl1_cyc == 0 && n_cmd == 6, "R8", "sequence stopped at timeout", n_cmd, 6);
        check(memctl_cyc < 0 && aref_cyc < 0, "R8", "no tail after timeout", aref_cyc, -1);
        check_hold(1, 1'b0);
    endtask

    task automatic test_last_poll();
        run_seq(1'b0, 1'b1, POLL_MAX, 2, 1'b0);
        check(int'(err) == 0, "R8", "completion on last poll accepted", int'(err), 0);
        check(lvl0_cyc == POLL_MAX && lvl1_cyc == 2, "R8", "last-poll window", lvl0_cyc, POLL_MAX);
        check(aref_cyc == memctl_cyc + 1, "R10", "last-poll run tail", aref_cyc, memctl_cyc + 1);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_reset();
        test_cold_two();
        test_cold_one();
        test_resume(1'b1);
        test_resume(1'b0);
        test_zq_fail();
        test_timeout();
        test_last_poll();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule